// File: doc/BRIEF.md
# 100 Mb/s Link Qualification Monitor

This block decides whether a 100 Mb/s receive channel has a usable link. It watches a signal-level-valid input from the analog front end and a strobe that pulses once for every idle or valid-symbol pattern the descrambler recognises. From the strobes it keeps its own descrambler-lock state. Lock is gained after a run of strobes and lost when no strobe arrives within a timeout window. From lock and signal level it drives a link-status output.

The block offers two policies for holding link. With the signal-only policy, link stays up while the signal level is valid, even if lock is lost. With the strict policy, link also needs lock to persist. The lock-loss window is either the normal length (722 us at 25 MHz) or the extended length (2 ms). The extended length lets jumbo frames above 9k bytes pass without a false loss of sync. A force input makes the block treat the signal level as valid at all times. All window lengths and the strobe run length are parameters, so a short simulation can use small values.

Top module: `link_qual_mon`

## Requirements
- R1: While the synchronous reset `rst` is high, both `scr_locked_o` and `link_up_o` read 0 after each clock edge.
- R2: `scr_locked_o` goes to 1 after the clock edge that samples the LOCK_COUNT-th strobe in a run. A run is a set of strobes in which no timeout expires between one strobe and the next. After LOCK_COUNT-1 strobes it is still 0.
- R3: With `cfg_long_tmo_i` = 0, the lock is lost SHORT_TICKS edges after the edge that sampled the last strobe, and not earlier.
- R4: With `cfg_long_tmo_i` = 1, the lock is lost LONG_TICKS edges after the edge that sampled the last strobe, and not earlier.
- R5: Every strobe restarts the timeout window. Strobes spaced closer than the window keep the lock up for any length of time.
- R6: `link_up_o` never rises without lock. It rises one edge after lock and a valid signal level are both present.
- R7: With `cfg_sig_only_hold_i` = 1, loss of lock leaves `link_up_o` at 1 while the signal stays valid.
- R8: With `cfg_sig_only_hold_i` = 0, `link_up_o` falls in the same cycle in which `scr_locked_o` falls.
- R9: `link_up_o` falls in the same cycle in which the effective signal level deasserts, under either hold policy.
- R10: With `cfg_force_sd_i` = 1, the signal level counts as valid whatever the value of `sig_level_i`.
- R11: A timeout that expires before the run is complete discards the strobes counted so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_level_i | input | 1 | Receive signal level is valid |
| sync_stb_i | input | 1 | One-cycle pulse per recognised idle or valid-symbol pattern |
| cfg_sig_only_hold_i | input | 1 | 1: hold link on signal alone; 0: also require lock |
| cfg_force_sd_i | input | 1 | Treat the signal level as always valid |
| cfg_long_tmo_i | input | 1 | 1: use the extended lock-loss window |
| scr_locked_o | output | 1 | Descrambler lock state |
| link_up_o | output | 1 | Link status |

## Verification
The window check in the assertions assumes that `cfg_long_tmo_i` does not change while the lock is held. A switch from the long window to the short one in mid-count would end the lock at a point that the checker's idle counter does not model. The stimulus therefore changes that bit only after lock has been lost. It also changes the hold policy only while the lock is down. `sync_stb_i` is driven as a single-cycle pulse, and inputs change half a cycle away from the sampling edge.

// File: rtl/lqm_pkg.sv
package lqm_pkg;
   typedef enum logic {
      LINK_DOWN = 1'b0,
      LINK_UP   = 1'b1
   } link_state_e;
endpackage

// File: rtl/lqm_lock_timer.sv
// Lock-loss window counter: restarts on each strobe, pulses expire_o at window end.
module lqm_lock_timer #(
   parameter int SHORT_TICKS = 18050,
   parameter int LONG_TICKS  = 50000
) (
   input  logic clk,
   input  logic rst,
   input  logic sync_stb,
   input  logic long_sel,
   output logic expire_o
);
   localparam int TW = $clog2(LONG_TICKS + 1);
   localparam logic [TW-1:0] SHORT_LAST = TW'(SHORT_TICKS - 1);
   localparam logic [TW-1:0] LONG_LAST  = TW'(LONG_TICKS - 1);

   logic [TW-1:0] tick_q;
   logic [TW-1:0] last_tick;

   generate
      if (SHORT_TICKS == LONG_TICKS) begin : g_single_window
         assign last_tick = LONG_LAST;
         logic unused_sel;
         assign unused_sel = long_sel;
      end else begin : g_dual_window
         assign last_tick = long_sel ? LONG_LAST : SHORT_LAST;
      end
   endgenerate

   assign expire_o = !sync_stb && (tick_q >= last_tick);

   always_ff @(posedge clk) begin
      if (rst || sync_stb || expire_o) begin
         tick_q <= '0;
      end else begin
         tick_q <= tick_q + 1'b1;
      end
   end
endmodule

// File: rtl/lqm_lock_acq.sv
// Counts a run of strobes into lock; a window expiry clears both the run and the lock.
module lqm_lock_acq #(
   parameter int LOCK_COUNT = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic sync_stb,
   input  logic expire,
   output logic locked_o
);
   localparam int CW = (LOCK_COUNT > 2) ? $clog2(LOCK_COUNT) : 1;
   localparam logic [CW-1:0] RUN_LAST = CW'(LOCK_COUNT - 1);

   logic [CW-1:0] run_q;
   logic          locked_q;

   always_ff @(posedge clk) begin
      if (rst || expire) begin
         run_q    <= '0;
         locked_q <= 1'b0;
      end else if (sync_stb && !locked_q) begin
         if (run_q == RUN_LAST) begin
            run_q    <= '0;
            locked_q <= 1'b1;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign locked_o = locked_q;
endmodule

// File: rtl/lqm_link_ctrl.sv
// Link state machine with a selectable hold policy and same-cycle drop gating.
module lqm_link_ctrl
   import lqm_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic sig_ok,
   input  logic locked,
   input  logic hold_on_signal,
   output logic link_up_o
);
   link_state_e state_q, state_d;
   logic        hold_ok;

   assign hold_ok = sig_ok && (hold_on_signal || locked);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LINK_DOWN: if (sig_ok && locked) state_d = LINK_UP;
         LINK_UP:   if (!hold_ok)         state_d = LINK_DOWN;
         default:                         state_d = LINK_DOWN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= LINK_DOWN;
      else     state_q <= state_d;
   end

   assign link_up_o = (state_q == LINK_UP) && hold_ok;
endmodule

// File: rtl/link_qual_mon.sv
module link_qual_mon #(
   parameter int LOCK_COUNT  = 16,
   parameter int SHORT_TICKS = 18050,
   parameter int LONG_TICKS  = 50000
) (
   input  logic clk,
   input  logic rst,
   input  logic sig_level_i,
   input  logic sync_stb_i,
   input  logic cfg_sig_only_hold_i,
   input  logic cfg_force_sd_i,
   input  logic cfg_long_tmo_i,
   output logic scr_locked_o,
   output logic link_up_o
);
   generate
      if (LOCK_COUNT < 2) begin : g_bad_lock_count
         $fatal(1, "LOCK_COUNT must be at least 2");
      end
      if (SHORT_TICKS < 2) begin : g_bad_short
         $fatal(1, "SHORT_TICKS must be at least 2");
      end
      if (LONG_TICKS < SHORT_TICKS) begin : g_bad_long
         $fatal(1, "LONG_TICKS must not be below SHORT_TICKS");
      end
   endgenerate

   logic sig_ok;
   logic expire;
   logic locked;

   assign sig_ok = sig_level_i || cfg_force_sd_i;

   lqm_lock_timer #(
      .SHORT_TICKS(SHORT_TICKS),
      .LONG_TICKS (LONG_TICKS)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .sync_stb (sync_stb_i),
      .long_sel (cfg_long_tmo_i),
      .expire_o (expire)
   );

   lqm_lock_acq #(
      .LOCK_COUNT(LOCK_COUNT)
   ) u_acq (
      .clk      (clk),
      .rst      (rst),
      .sync_stb (sync_stb_i),
      .expire   (expire),
      .locked_o (locked)
   );

   lqm_link_ctrl u_link (
      .clk            (clk),
      .rst            (rst),
      .sig_ok         (sig_ok),
      .locked         (locked),
      .hold_on_signal (cfg_sig_only_hold_i),
      .link_up_o      (link_up_o)
   );

   assign scr_locked_o = locked;
endmodule

// File: rtl/lqm_checker.sv
module lqm_checker #(
   parameter int SHORT_TICKS = 18050,
   parameter int LONG_TICKS  = 50000
) (
   input logic clk,
   input logic rst,
   input logic sig_level_i,
   input logic sync_stb_i,
   input logic cfg_sig_only_hold_i,
   input logic cfg_force_sd_i,
   input logic cfg_long_tmo_i,
   input logic scr_locked_o,
   input logic link_up_o
);
   localparam int IW = $clog2(LONG_TICKS + 2);
   localparam logic [IW-1:0] IDLE_MAX = {IW{1'b1}};

   logic [IW-1:0] idle_q;
   logic [IW-1:0] window;

   assign window = cfg_long_tmo_i ? IW'(LONG_TICKS) : IW'(SHORT_TICKS);

   always_ff @(posedge clk) begin
      if (rst || sync_stb_i)      idle_q <= '0;
      else if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      $past(rst) |-> (!scr_locked_o && !link_up_o)); // R1

   AST_LOCK_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
      $rose(scr_locked_o) |-> $past(sync_stb_i)); // R2

   AST_LOCK_WITHIN_WINDOW: assert property (@(posedge clk) disable iff (rst)
      scr_locked_o |-> (idle_q < window)); // R3

   AST_LINK_RISE_LOCKED: assert property (@(posedge clk) disable iff (rst)
      $rose(link_up_o) |-> $past(scr_locked_o)); // R6

   AST_STRICT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
      (!cfg_sig_only_hold_i && link_up_o) |-> scr_locked_o); // R8

   AST_LINK_NEEDS_SIGNAL: assert property (@(posedge clk) disable iff (rst)
      link_up_o |-> (sig_level_i || cfg_force_sd_i)); // R9
endmodule

bind link_qual_mon lqm_checker #(
   .SHORT_TICKS(SHORT_TICKS),
   .LONG_TICKS (LONG_TICKS)
) u_chk (
   .clk                 (clk),
   .rst                 (rst),
   .sig_level_i         (sig_level_i),
   .sync_stb_i          (sync_stb_i),
   .cfg_sig_only_hold_i (cfg_sig_only_hold_i),
   .cfg_force_sd_i      (cfg_force_sd_i),
   .cfg_long_tmo_i      (cfg_long_tmo_i),
   .scr_locked_o        (scr_locked_o),
   .link_up_o           (link_up_o)
);

// File: tb/link_qual_mon_test.sv
`timescale 1ns/1ps
module link_qual_mon_test;
   localparam int LC = 4;
   localparam int SW = 20;
   localparam int LW = 50;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sig = 1'b0;
   logic stb = 1'b0;
   logic hold = 1'b1;
   logic force_sd = 1'b0;
   logic long_t = 1'b0;
   logic locked, link;

   int checks = 0;
   int fails  = 0;

   string      tag_q[$];
   logic [1:0] exp_q[$];

   always #4 clk = ~clk;

   link_qual_mon #(.LOCK_COUNT(LC), .SHORT_TICKS(SW), .LONG_TICKS(LW)) uut (
      .clk(clk), .rst(rst), .sig_level_i(sig), .sync_stb_i(stb),
      .cfg_sig_only_hold_i(hold), .cfg_force_sd_i(force_sd),
      .cfg_long_tmo_i(long_t), .scr_locked_o(locked), .link_up_o(link)
   );

   task automatic compare(input string tag, input logic [1:0] exp);
      checks++;
      if ({locked, link} !== exp) begin
         fails++;
         $display("FAIL %s: lock/link actual %b%b expected %b%b", tag, locked, link, exp[1], exp[0]);
      end
   endtask

   // driver side: queue what must hold after the edge just taken
   task automatic expect_after(input string tag, input logic l, input logic k);
      tag_q.push_back(tag);
      exp_q.push_back({l, k});
   endtask

   // monitor: pops queued items shortly after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (exp_q.size() > 0) compare(tag_q.pop_front(), exp_q.pop_front());
      end
   end

   task automatic cyc(input logic s);
      @(negedge clk);
      stb = s;
      @(posedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0);
   endtask

   // n strobes spaced gap cycles apart, ending on the edge of the last strobe
   task automatic train(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         if (i > 0) idle(gap - 1);
         cyc(1'b1);
      end
   endtask

   initial begin
      idle(3);
      expect_after("R1 reset", 1'b0, 1'b0);
      @(negedge clk); rst = 1'b0;

      // lock with no signal: no link (R2, R6)
      train(LC - 1, 4);
      expect_after("R2 one short of run", 1'b0, 1'b0);
      idle(3); cyc(1'b1);
      expect_after("R2 run complete", 1'b1, 1'b0);
      idle(3);
      expect_after("R6 no link without signal", 1'b1, 1'b0);
      @(negedge clk); sig = 1'b1; #1;
      compare("R6 link not yet up", 2'b10);
      cyc(1'b1);
      expect_after("R6 link one edge later", 1'b1, 1'b1);

      // strobes keep lock well past window (R5)
      train(12, 4);
      expect_after("R5 lock kept by strobes", 1'b1, 1'b1);

      // signal-only hold: lock loss keeps link (R3, R7)
      idle(SW - 1);
      expect_after("R3 lock before window end", 1'b1, 1'b1);
      cyc(1'b0);
      expect_after("R7 lock lost link held", 1'b0, 1'b1);

      // signal drop (R9)
      @(negedge clk); sig = 1'b0; #1;
      compare("R9 same-cycle drop hold policy", 2'b00);
      idle(SW + 5);

      // strict policy (R8)
      @(negedge clk); hold = 1'b0; sig = 1'b1;
      train(LC, 4);
      cyc(1'b0);
      expect_after("R8 link up strict", 1'b1, 1'b1);
      cyc(1'b1);
      idle(SW - 1);
      expect_after("R8 before window end", 1'b1, 1'b1);
      cyc(1'b0);
      expect_after("R8 lock and link fall together", 1'b0, 1'b0);

      // signal drop under strict policy (R9)
      train(LC, 4); idle(2);
      expect_after("R9 relock strict", 1'b1, 1'b1);
      @(negedge clk); sig = 1'b0; #1;
      compare("R9 same-cycle drop strict", 2'b10);
      idle(SW + 5);
      expect_after("R9 down after timeout", 1'b0, 1'b0);

      // partial run discarded by expiry (R11)
      train(LC - 1, 4);
      idle(SW + 5);
      train(LC - 1, 4);
      expect_after("R11 old strobes discarded", 1'b0, 1'b0);
      idle(3); cyc(1'b1);
      expect_after("R11 fresh run locks", 1'b1, 1'b0);
      idle(SW + 5);

      // extended window (R4)
      @(negedge clk); long_t = 1'b1; sig = 1'b1; hold = 1'b1;
      train(LC, 4);
      idle(SW + 2);
      expect_after("R4 lock past short window", 1'b1, 1'b1);
      idle(LW - SW - 3);
      expect_after("R4 lock before long window end", 1'b1, 1'b1);
      cyc(1'b0);
      expect_after("R4 lock lost at long window", 1'b0, 1'b1);
      @(negedge clk); sig = 1'b0;
      idle(LW + 5);

      // force signal (R10)
      @(negedge clk); long_t = 1'b0; force_sd = 1'b1;
      train(LC, 4); idle(1);
      expect_after("R10 link with forced signal", 1'b1, 1'b1);
      @(negedge clk); force_sd = 1'b0; #1;
      compare("R10 force removed drops link", 2'b10);
      idle(2);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 8);
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule